// File: doc/BRIEF.md
# Bi-endian address swizzle unit

This unit sits between the effective-address stage of a load/store path and a memory port that is eight bytes wide and ordered big-endian: byte offset 0 of a memory word holds the most significant byte. Big-endian is the native order, and in it an address names the most significant byte of a multibyte scalar. A little-endian mode bit, which belongs to the running process's context, is sampled with every request. While it is set, the unit flips the low three address bits with a constant picked by the access size. The data bytes therefore never have to be reversed.

The flip only gives the right bytes for accesses that are aligned to their own size. For that reason, a misaligned request in little-endian mode is refused with an alignment fault. In big-endian mode, misaligned requests pass through unchanged. When such a request runs past the end of its doubleword, the unit enables the lanes that fall inside the current doubleword and raises a crossing flag. All results are registered, so each request produces a valid strobe one cycle later.

Top module: `lsu_endian_swizzle`

## Requirements
- R1: While reset is held, and on the first cycle after it, `vld_o`, `lane_en_o`, `fault_o` and `cross_o` are all zero.
- R2: `vld_o` equals `req_i` of the previous cycle. After a cycle with no request, `lane_en_o`, `fault_o` and `cross_o` are zero.
- R3: When `le_mode_i` is 0 at request time, `addr_o` equals the requested address bit for bit.
- R4: When `le_mode_i` is 1 and `size_i` is 0 (byte), `addr_o` is the request address with its low three bits XORed with 7 and every other bit unchanged.
- R5: When `le_mode_i` is 1, the low three bits are XORed with 6 for `size_i`=1 (halfword), with 4 for `size_i`=2 (word) and with 0 for `size_i`=3 (doubleword).
- R6: When `le_mode_i` is 1 and the address is not a multiple of the access size (2, 4 or 8 bytes), `fault_o` is 1 and both `lane_en_o` and `cross_o` are 0.
- R7: When `le_mode_i` is 0, `fault_o` is 0 for every address and size.
- R8: For a request that does not fault, `lane_en_o[i]` is 1 exactly for each byte offset i from o to o+n-1 that is below 8. Here o is `addr_o[2:0]` and n is 1, 2, 4 or 8 for `size_i` 0 to 3. Bit 0 is the most significant byte of the memory word.
- R9: `cross_o` is 1 exactly when a non-faulting request has o+n greater than 8.
- R10: Mode and size are taken from the request's own cycle, so back-to-back requests that alternate mode are each handled under their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W | Effective address |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| le_mode_i | input | 1 | 1 selects little-endian mode for this request |
| vld_o | output | 1 | Result valid, one cycle after `req_i` |
| addr_o | output | ADDR_W | Address after the flip |
| lane_en_o | output | LANES | Byte-lane enables, bit i = byte offset i |
| fault_o | output | 1 | Alignment fault |
| cross_o | output | 1 | Access runs past the end of its doubleword |

## Verification
The hardest case to reach from the ports is a change of mode between two requests that follow each other with no gap, where the second request's address is misaligned only for its own size. This case shows whether mode and size are sampled per request. The stimulus issues requests on every cycle with the mode bit, the size and the low address bits drawn at random. Directed vectors then cover every byte offset in little-endian mode, the crossing cases in big-endian mode, and idle cycles placed between requests.

// File: rtl/lsu_swz_pkg.sv
package lsu_swz_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DBL  = 2'd3
  } acc_size_e;

  // Number of bytes touched by an access of the given size code.
  function automatic logic [4:0] acc_bytes(input logic [1:0] sz);
    return 5'd1 << sz;
  endfunction

  // Little-endian offset flip: word width minus access width.
  function automatic logic [4:0] le_flip(input logic [1:0] sz, input int lanes);
    logic [4:0] lanes_v;
    lanes_v = 5'(lanes);
    return lanes_v - acc_bytes(sz);
  endfunction
endpackage

// File: rtl/swz_addr_xform.sv
module swz_addr_xform
  import lsu_swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              le_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misal_o,
  output logic              fault_o
);
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0] off_in;
  logic [OFS_W-1:0] flip;
  logic [OFS_W-1:0] size_mask;

  assign off_in    = addr_i[OFS_W-1:0];
  assign size_mask = OFS_W'(acc_bytes(size_i) - 5'd1);
  assign flip      = le_i ? OFS_W'(le_flip(size_i, LANES)) : '0;
  assign misal_o   = (off_in & size_mask) != '0;
  assign fault_o   = le_i & misal_o;
  assign addr_o    = {addr_i[ADDR_W-1:OFS_W], off_in ^ flip};
endmodule

// File: rtl/swz_lane_mask.sv
module swz_lane_mask
  import lsu_swz_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [$clog2(LANES)-1:0] off_i,
  input  logic [1:0]               size_i,
  input  logic                     kill_i,
  output logic [LANES-1:0]         lanes_o,
  output logic                     cross_o
);
  localparam int OFS_W = $clog2(LANES);
  localparam int EW    = OFS_W + 2;

  logic [EW-1:0] start_w;
  logic [EW-1:0] end_w;

  assign start_w = EW'(off_i);
  assign end_w   = start_w + EW'(acc_bytes(size_i));
  assign cross_o = !kill_i && (end_w > EW'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes_o[i] = !kill_i && (EW'(i) >= start_w) && (EW'(i) < end_w);
  end
endmodule

// File: rtl/lsu_endian_swizzle.sv
module lsu_endian_swizzle
  import lsu_swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              le_mode_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic              fault_o,
  output logic              cross_o
);
  localparam int OFS_W = $clog2(LANES);

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] xaddr_w;
  logic              misal_w;
  logic              fault_w;
  logic [LANES-1:0]  lanes_w;
  logic              cross_w;

  swz_addr_xform #(.ADDR_W(ADDR_W), .LANES(LANES)) xform_i (
    .addr_i (addr_i),
    .size_i (size_i),
    .le_i   (le_mode_i),
    .addr_o (xaddr_w),
    .misal_o(misal_w),
    .fault_o(fault_w)
  );

  swz_lane_mask #(.LANES(LANES)) mask_i (
    .off_i  (xaddr_w[OFS_W-1:0]),
    .size_i (size_i),
    .kill_i (fault_w),
    .lanes_o(lanes_w),
    .cross_o(cross_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o     <= 1'b0;
      addr_o    <= '0;
      lane_en_o <= '0;
      fault_o   <= 1'b0;
      cross_o   <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        addr_o    <= xaddr_w;
        lane_en_o <= lanes_w;
        fault_o   <= fault_w;
        cross_o   <= cross_w;
      end else begin
        lane_en_o <= '0;
        fault_o   <= 1'b0;
        cross_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsu_endian_swizzle_chk.sv
module lsu_endian_swizzle_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              le_mode_i,
  input logic              vld_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [LANES-1:0]  lane_en_o,
  input logic              fault_o,
  input logic              cross_o,
  input logic              misal_w
);
  localparam int OFS_W = $clog2(LANES);

  assert_req_to_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!vld_o && lane_en_o == '0 && !fault_o && !cross_o));

  assert_be_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !le_mode_i) |=> addr_o == $past(addr_i));

  assert_le_byte_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && le_mode_i && size_i == 2'd0) |=>
      addr_o == ($past(addr_i) ^ ADDR_W'(LANES - 1)));

  assert_le_misal_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && le_mode_i && misal_w) |=> (fault_o && lane_en_o == '0 && !cross_o));

  assert_be_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !le_mode_i) |=> !fault_o);

  assert_dbl_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && size_i == 2'd3 && addr_i[OFS_W-1:0] == '0) |=> lane_en_o == '1);

  assert_cross_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cross_o |-> (vld_o && !fault_o && lane_en_o[LANES-1]));
endmodule

bind lsu_endian_swizzle lsu_endian_swizzle_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .addr_i   (addr_i),
  .size_i   (size_i),
  .le_mode_i(le_mode_i),
  .vld_o    (vld_o),
  .addr_o   (addr_o),
  .lane_en_o(lane_en_o),
  .fault_o  (fault_o),
  .cross_o  (cross_o),
  .misal_w  (misal_w)
);

// File: tb/lsu_endian_swizzle_tb_top.sv
`timescale 1ns/1ps
module lsu_endian_swizzle_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        le_mode_i = 1'b0;
  logic        vld_o;
  logic [31:0] addr_o;
  logic [7:0]  lane_en_o;
  logic        fault_o;
  logic        cross_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lsu_endian_swizzle dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .size_i(size_i),
    .le_mode_i(le_mode_i), .vld_o(vld_o), .addr_o(addr_o), .lane_en_o(lane_en_o),
    .fault_o(fault_o), .cross_o(cross_o)
  );

  function automatic logic [31:0] e_addr(input logic [31:0] a, input logic [1:0] sz, input logic le);
    if (!le) return a;
    case (sz)
      2'd0:    return a ^ 32'd7;
      2'd1:    return a ^ 32'd6;
      2'd2:    return a ^ 32'd4;
      default: return a;
    endcase
  endfunction

  function automatic logic e_fault(input logic [31:0] a, input logic [1:0] sz, input logic le);
    return le && ((sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0) ||
                  (sz == 2'd3 && a[2:0] != 3'd0));
  endfunction

  function automatic logic [15:0] e_span(input logic [31:0] a, input logic [1:0] sz, input logic le);
    logic [15:0] run;
    run = (16'd1 << (1 << sz)) - 16'd1;
    return run << e_addr(a, sz, le)[2:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge; its result is sampled one falling edge later.
  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic le);
    logic        f;
    logic [15:0] sp;
    req_i = 1'b1; addr_i = a; size_i = sz; le_mode_i = le;
    f  = e_fault(a, sz, le);
    sp = e_span(a, sz, le);
    @(negedge clk);
    check("R2 vld", 32'(vld_o), 32'd1);
    check(le ? (sz == 2'd0 ? "R4 addr" : "R5 addr") : "R3 addr", addr_o, e_addr(a, sz, le));
    check(le ? "R6 fault" : "R7 fault", 32'(fault_o), 32'(f));
    check(f ? "R6 lanes" : "R8 lanes", 32'(lane_en_o), f ? 32'd0 : 32'(sp[7:0]));
    check("R9 cross", 32'(cross_o), 32'(!f && sp[15:8] != 8'd0));
  endtask

  task automatic idle();
    req_i = 1'b0;
    @(negedge clk);
    check("R2 idle vld", 32'(vld_o), 32'd0);
    check("R2 idle lanes", 32'(lane_en_o), 32'd0);
    check("R2 idle flags", {30'd0, fault_o, cross_o}, 32'd0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 vld", 32'(vld_o), 32'd0);
    check("R1 lanes", 32'(lane_en_o), 32'd0);
    check("R1 flags", {30'd0, fault_o, cross_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {23'd0, vld_o, lane_en_o}, 32'd0);

    // R4: every byte offset in little-endian mode
    for (int o = 0; o < 8; o++) issue(32'h1000_0000 + 32'(o), 2'd0, 1'b1);
    // R5 and R6: aligned and misaligned wider accesses in little-endian mode
    issue(32'h0000_0102, 2'd1, 1'b1);
    issue(32'h0000_0103, 2'd1, 1'b1);
    issue(32'h0000_0204, 2'd2, 1'b1);
    issue(32'h0000_0206, 2'd2, 1'b1);
    issue(32'h0000_0308, 2'd3, 1'b1);
    issue(32'h0000_030C, 2'd3, 1'b1);
    idle();
    // R7, R8, R9: big-endian misaligned and crossing cases
    issue(32'h0000_0406, 2'd2, 1'b0);
    issue(32'h0000_0405, 2'd3, 1'b0);
    issue(32'h0000_0407, 2'd1, 1'b0);
    issue(32'h0000_0407, 2'd0, 1'b0);
    issue(32'h0000_0403, 2'd2, 1'b0);
    idle();
    // R10: mode changes between back-to-back requests
    issue(32'h0000_0502, 2'd2, 1'b0);
    issue(32'h0000_0502, 2'd2, 1'b1);
    issue(32'h0000_0501, 2'd0, 1'b0);
    issue(32'h0000_0501, 2'd0, 1'b1);
    // Random mix, R10 exercised by alternating mode with no gap
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = $urandom();
      issue(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 9) == 0) idle();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule